// File: doc/BRIEF.md
# Single-Byte I2C Transaction Sequencer

This block carries out one complete I2C byte transfer, read or write, by working the register interface of an I2C byte master. That work would otherwise be done by processor code. The master sits beside the sequencer. It exposes two registers, control/status and data, over a one-access-per-cycle register port. It raises an interrupt request each time a byte transfer on the wire finishes.

The user presents a command byte and, for writes, a payload byte, then pulses `go`. Bit 0 of the command byte selects the direction. The sequencer first waits for any STOP condition still on the wire to finish. It then issues START and the command byte, and steps through a two-interrupt sequence for reads or for writes. While it works, `busy` is high. When a read finishes, the received byte is presented on `rd_byte`.

On the read path the STOP request and the fetch of the received byte take consecutive cycles. The byte is therefore collected while the master is still sending STOP, and before the master stops answering register accesses.

Top module: `i2c_byte_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `m_wr` and `m_rd` are 0 and `rd_byte` is 0.
- R2: A `go` pulse while `busy` is 0 makes `busy` 1 at the next clock edge and latches `cmd_byte` and `wr_byte`. A `go` pulse while `busy` is 1 is ignored: no operand changes and no extra transaction follows.
- R3: `m_sel` 0 selects the control register and 1 selects the data register. After accepting `go`, the block reads the control register every cycle until bit 6 (STOP pending) reads 0. It makes no write while that bit reads 1.
- R4: The first two writes of every transaction are the control register with 0x80 (bit 7, START), then, on the very next cycle, the data register with the command byte.
- R5: When command bit 0 is 1 (read), the first `m_irq` produces a control write of 0x20 (bit 5, suppress acknowledge on the last byte), followed on the next cycle by a discarded read of the data register.
- R6: On the read path the second `m_irq` produces a control write of 0x40 (bit 6, STOP), and the data register is read on the very next cycle. That byte appears on `rd_byte` at the same edge at which `busy` falls.
- R7: When command bit 0 is 0 (write), the first `m_irq` produces a data register write of the latched `wr_byte`. The second produces a control write of 0x40, after which `busy` falls.
- R8: `m_irq` is ignored while idle and while an access is being issued. It causes no access until the sequence is waiting for it.
- R9: `rd_byte` keeps its value at all times except at the completion of a read. Write transactions leave it unchanged.
- R10: `m_wr` and `m_rd` are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe, one cycle |
| cmd_byte | input | 8 | Address/command byte; bit 0 = 1 read, 0 write |
| wr_byte | input | 8 | Payload for a write transaction |
| busy | output | 1 | Transaction in progress |
| rd_byte | output | 8 | Byte received by the last read |
| m_wr | output | 1 | Register write strobe to the master |
| m_rd | output | 1 | Register read strobe to the master |
| m_sel | output | 1 | Register select: 0 control, 1 data |
| m_wdata | output | 8 | Register write data |
| m_rdata | input | 8 | Register read data, valid in the cycle of `m_rd` |
| m_irq | input | 1 | Master interrupt request, cleared by any access |

## Verification
The hardest situation to bring about is a STOP still in progress when a new `go` arrives. A careless sequencer would write START into a master that is ignoring it. The bench's behavioural master keeps STOP pending for several cycles after each STOP write. Each table entry starts its transaction on the cycle after `busy` falls, and some entries also preload a longer pending STOP. Any write that lands while STOP is pending is counted as a violation. The same model notes the cycle of the final data read relative to the STOP write, which confirms that the byte was fetched while STOP was still on the wire.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // Sequencer phases: one register access per access phase.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_POLL,
    PH_START,
    PH_ADDR,
    PH_WAIT,
    PH_LASTRD,
    PH_DUMMY,
    PH_STOP,
    PH_FETCH,
    PH_DATA
  } phase_t;

  // Interrupt-driven step: 0/1 read path, 2/3 write path.
  typedef enum logic [1:0] {
    SQ_RD_ARM  = 2'd0,
    SQ_RD_END  = 2'd1,
    SQ_WR_DATA = 2'd2,
    SQ_WR_END  = 2'd3
  } step_t;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

endpackage

// File: rtl/i2cseq_accept.sv
module i2cseq_accept #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          busy,
  input  logic [DW-1:0] cmd_in,
  input  logic [DW-1:0] wdat_in,
  output logic          start,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] wdat_q,
  output logic          is_read
);

  assign start   = go && !busy;
  assign is_read = cmd_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      wdat_q <= '0;
    end else if (start) begin
      cmd_q  <= cmd_in;
      wdat_q <= wdat_in;
    end
  end

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   is_read,
  input  logic   stop_flag,
  input  logic   irq,
  output phase_t phase_q,
  output phase_t phase_n,
  output logic   busy
);

  step_t step_q, step_n;

  always_comb begin
    phase_n = phase_q;
    step_n  = step_q;
    case (phase_q)
      PH_IDLE:   if (start) phase_n = PH_POLL;
      PH_POLL:   if (!stop_flag) phase_n = PH_START;
      PH_START:  phase_n = PH_ADDR;
      PH_ADDR: begin
        phase_n = PH_WAIT;
        step_n  = is_read ? SQ_RD_ARM : SQ_WR_DATA;
      end
      PH_WAIT: begin
        if (irq) begin
          case (step_q)
            SQ_RD_ARM:  phase_n = PH_LASTRD;
            SQ_WR_DATA: phase_n = PH_DATA;
            default:    phase_n = PH_STOP;
          endcase
        end
      end
      PH_LASTRD: phase_n = PH_DUMMY;
      PH_DUMMY: begin
        phase_n = PH_WAIT;
        step_n  = SQ_RD_END;
      end
      PH_DATA: begin
        phase_n = PH_WAIT;
        step_n  = SQ_WR_END;
      end
      // Fetch follows STOP with nothing in between.
      PH_STOP:   phase_n = (step_q == SQ_RD_END) ? PH_FETCH : PH_IDLE;
      PH_FETCH:  phase_n = PH_IDLE;
      default:   phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      step_q  <= SQ_RD_ARM;
      busy    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      step_q  <= step_n;
      busy    <= (phase_n != PH_IDLE);
    end
  end

endmodule

// File: rtl/i2cseq_busdrv.sv
module i2cseq_busdrv
  import i2cseq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int START_BIT  = 7,
  parameter int STOP_BIT   = 6,
  parameter int LASTRD_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase_n,
  input  logic [DW-1:0] cmd_q,
  input  logic [DW-1:0] wdat_q,
  output logic          m_wr,
  output logic          m_rd,
  output logic          m_sel,
  output logic [DW-1:0] m_wdata
);

  localparam logic [DW-1:0] ONE         = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] START_MASK  = ONE << START_BIT;
  localparam logic [DW-1:0] STOP_MASK   = ONE << STOP_BIT;
  localparam logic [DW-1:0] LASTRD_MASK = ONE << LASTRD_BIT;

  logic          wr_n, rd_n, sel_n;
  logic [DW-1:0] wdata_n;

  always_comb begin
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    sel_n   = SEL_CTRL;
    wdata_n = '0;
    case (phase_n)
      PH_POLL:   rd_n = 1'b1;
      PH_START:  begin wr_n = 1'b1; wdata_n = START_MASK; end
      PH_ADDR:   begin wr_n = 1'b1; sel_n = SEL_DATA; wdata_n = cmd_q; end
      PH_LASTRD: begin wr_n = 1'b1; wdata_n = LASTRD_MASK; end
      PH_DUMMY:  begin rd_n = 1'b1; sel_n = SEL_DATA; end
      PH_STOP:   begin wr_n = 1'b1; wdata_n = STOP_MASK; end
      PH_FETCH:  begin rd_n = 1'b1; sel_n = SEL_DATA; end
      PH_DATA:   begin wr_n = 1'b1; sel_n = SEL_DATA; wdata_n = wdat_q; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_wr    <= 1'b0;
      m_rd    <= 1'b0;
      m_sel   <= SEL_CTRL;
      m_wdata <= '0;
    end else begin
      m_wr    <= wr_n;
      m_rd    <= rd_n;
      m_sel   <= sel_n;
      m_wdata <= wdata_n;
    end
  end

endmodule

// File: rtl/i2cseq_result.sv
module i2cseq_result #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] m_rdata,
  output logic [DW-1:0] rd_byte
);

  always_ff @(posedge clk) begin
    if (rst)      rd_byte <= '0;
    else if (cap) rd_byte <= m_rdata;
  end

endmodule

// File: rtl/i2c_byte_sequencer.sv
module i2c_byte_sequencer
  import i2cseq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int START_BIT  = 7,
  parameter int STOP_BIT   = 6,
  parameter int LASTRD_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] cmd_byte,
  input  logic [DW-1:0] wr_byte,
  output logic          busy,
  output logic [DW-1:0] rd_byte,
  output logic          m_wr,
  output logic          m_rd,
  output logic          m_sel,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_irq
);

  logic          start, is_read;
  logic [DW-1:0] cmd_q, wdat_q;
  phase_t        phase_q, phase_n;

  i2cseq_accept #(.DW(DW)) u_accept (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .busy    (busy),
    .cmd_in  (cmd_byte),
    .wdat_in (wr_byte),
    .start   (start),
    .cmd_q   (cmd_q),
    .wdat_q  (wdat_q),
    .is_read (is_read)
  );

  i2cseq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_read   (is_read),
    .stop_flag (m_rdata[STOP_BIT]),
    .irq       (m_irq),
    .phase_q   (phase_q),
    .phase_n   (phase_n),
    .busy      (busy)
  );

  i2cseq_busdrv #(
    .DW         (DW),
    .START_BIT  (START_BIT),
    .STOP_BIT   (STOP_BIT),
    .LASTRD_BIT (LASTRD_BIT)
  ) u_busdrv (
    .clk     (clk),
    .rst     (rst),
    .phase_n (phase_n),
    .cmd_q   (cmd_q),
    .wdat_q  (wdat_q),
    .m_wr    (m_wr),
    .m_rd    (m_rd),
    .m_sel   (m_sel),
    .m_wdata (m_wdata)
  );

  i2cseq_result #(.DW(DW)) u_result (
    .clk     (clk),
    .rst     (rst),
    .cap     (phase_q == PH_FETCH),
    .m_rdata (m_rdata),
    .rd_byte (rd_byte)
  );

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker #(
  parameter int DW         = 8,
  parameter int START_BIT  = 7,
  parameter int STOP_BIT   = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          busy,
  input logic [DW-1:0] rd_byte,
  input logic          m_wr,
  input logic          m_rd,
  input logic          m_sel,
  input logic [DW-1:0] m_wdata
);

  localparam logic [DW-1:0] ONE        = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] START_MASK = ONE << START_BIT;
  localparam logic [DW-1:0] STOP_MASK  = ONE << STOP_BIT;

  logic saw_start, rd_path;

  // Direction observed at the port: bit 0 of the data write after START.
  always_ff @(posedge clk) begin
    if (rst) begin
      saw_start <= 1'b0;
      rd_path   <= 1'b0;
    end else begin
      saw_start <= m_wr && !m_sel && (m_wdata == START_MASK);
      if (saw_start && m_wr && m_sel) rd_path <= m_wdata[0];
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !m_wr && !m_rd && rd_byte == '0));

  assert_go_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && go) |=> busy);

  assert_cmd_after_start_R4: assert property (@(posedge clk) disable iff (rst)
    (m_wr && !m_sel && m_wdata == START_MASK) |=> (m_wr && m_sel));

  assert_fetch_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (m_wr && !m_sel && m_wdata == STOP_MASK && rd_path) |=> (m_rd && m_sel));

  assert_write_done_R7: assert property (@(posedge clk) disable iff (rst)
    (m_wr && !m_sel && m_wdata == STOP_MASK && !rd_path) |=> !busy);

  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go) |=> (!m_wr && !m_rd));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(rd_byte));

  assert_one_access_R10: assert property (@(posedge clk) disable iff (rst)
    !(m_wr && m_rd));

endmodule

bind i2c_byte_sequencer i2cseq_checker #(
  .DW        (DW),
  .START_BIT (START_BIT),
  .STOP_BIT  (STOP_BIT)
) u_checker (
  .clk     (clk),
  .rst     (rst),
  .go      (go),
  .busy    (busy),
  .rd_byte (rd_byte),
  .m_wr    (m_wr),
  .m_rd    (m_rd),
  .m_sel   (m_sel),
  .m_wdata (m_wdata)
);

// File: tb/tb_i2c_byte_sequencer.sv
module tb_i2c_byte_sequencer;

  localparam int STOP_LEN = 6;
  localparam int IRQ_LAT  = 4;
  localparam int NVEC     = 6;
  // {cmd, wdata, rx byte, preloaded STOP cycles}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h41, 8'h00, 8'hA5, 8'd0},
    {8'h42, 8'h3C, 8'h00, 8'd0},
    {8'h41, 8'h00, 8'h5A, 8'd5},
    {8'h42, 8'hC3, 8'h11, 8'd9},
    {8'hFF, 8'h00, 8'h00, 8'd0},
    {8'hFE, 8'hFF, 8'hEE, 8'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       go = 1'b0;
  logic [7:0] cmd = 8'h00, wd = 8'h00;
  logic       busy, m_wr, m_rd, m_sel, m_irq;
  logic [7:0] rd_byte, m_wdata, m_rdata;

  // Behavioural master model
  int         stop_cnt, irq_cnt;
  logic       irq_m, irq_force = 1'b0;
  logic [7:0] rx_val = 8'h00;
  logic       pre_req = 1'b0;
  int         pre_val = 0;
  logic [9:0] log_e [128];
  int         log_c [128];
  int         log_n, poll_n, viol_n, both_n, stopw_cyc, fetch_cyc;
  int         cyc = 0;

  int n_chk = 0, n_fail = 0;

  assign m_irq   = irq_m | irq_force;
  assign m_rdata = m_sel ? rx_val : {1'b0, (stop_cnt != 0), 6'b0};

  i2c_byte_sequencer dut (
    .clk(clk), .rst(rst), .go(go), .cmd_byte(cmd), .wr_byte(wd),
    .busy(busy), .rd_byte(rd_byte), .m_wr(m_wr), .m_rd(m_rd),
    .m_sel(m_sel), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_irq(m_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      stop_cnt <= 0; irq_cnt <= 0; irq_m <= 1'b0;
      log_n <= 0; poll_n <= 0; viol_n <= 0; both_n <= 0;
      stopw_cyc <= 0; fetch_cyc <= 0;
    end else begin
      if (pre_req) stop_cnt <= pre_val;
      else if (stop_cnt != 0) stop_cnt <= stop_cnt - 1;
      if (irq_cnt != 0) begin
        irq_cnt <= irq_cnt - 1;
        if (irq_cnt == 1) irq_m <= 1'b1;
      end
      if (m_wr && m_rd) both_n <= both_n + 1;
      if (m_wr || m_rd) irq_m <= 1'b0;
      if (m_rd && !m_sel) poll_n <= poll_n + 1;
      else if (m_wr || m_rd) begin
        log_e[log_n] <= {m_wr, m_sel, (m_wr ? m_wdata : 8'h00)};
        log_c[log_n] <= cyc;
        log_n <= log_n + 1;
      end
      if (m_wr && !m_sel) begin
        if (stop_cnt != 0) viol_n <= viol_n + 1;
        else if (m_wdata == 8'h40) begin
          stop_cnt  <= STOP_LEN;
          stopw_cyc <= cyc;
        end
      end
      if ((m_wr || m_rd) && m_sel) begin
        if (stop_cnt == 0) irq_cnt <= IRQ_LAT;
        else fetch_cyc <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(!busy, "R2 transaction completes", busy, 0);
  endtask

  task automatic verify(input int base, input logic [7:0] c, input logic [7:0] w);
    logic [9:0] exp_e [6];
    int exp_n, mism;
    exp_e[0] = {2'b10, 8'h80};
    exp_e[1] = {2'b11, c};
    if (c[0]) begin
      exp_e[2] = {2'b10, 8'h20};
      exp_e[3] = {2'b01, 8'h00};
      exp_e[4] = {2'b10, 8'h40};
      exp_e[5] = {2'b01, 8'h00};
      exp_n = 6;
    end else begin
      exp_e[2] = {2'b11, w};
      exp_e[3] = {2'b10, 8'h40};
      exp_n = 4;
    end
    chk(log_n - base == exp_n, c[0] ? "R5 access count" : "R7 access count", log_n - base, exp_n);
    chk(log_e[base] == exp_e[0] && log_e[base+1] == exp_e[1] && log_c[base+1] == log_c[base] + 1,
        "R4 START then command", {log_e[base], log_e[base+1]}, {exp_e[0], exp_e[1]});
    mism = 0;
    for (int i = 2; i < exp_n; i++) if (log_e[base+i] != exp_e[i]) mism++;
    chk(mism == 0, c[0] ? "R5 R6 read sequence" : "R7 write sequence", mism, 0);
    if (c[0]) begin
      chk(log_c[base+3] == log_c[base+2] + 1, "R5 dummy read follows LASTRD", log_c[base+3], log_c[base+2] + 1);
      chk(fetch_cyc == stopw_cyc + 1, "R6 fetch right after STOP", fetch_cyc, stopw_cyc + 1);
    end
  endtask

  task automatic run_op(input logic [7:0] c, input logic [7:0] w, input logic [7:0] rx, input int pre);
    int base, pb;
    logic [7:0] old_rd;
    rx_val = rx;
    if (pre > 0) begin
      pre_val = pre;
      pre_req = 1'b1;
      @(negedge clk);
      pre_req = 1'b0;
    end
    base = log_n; pb = poll_n; old_rd = rd_byte;
    cmd = c; wd = w; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(busy == 1'b1, "R2 busy after go", busy, 1);
    wait_idle();
    verify(base, c, w);
    chk(poll_n - pb >= ((pre > 0) ? pre : 1) && viol_n == 0, "R3 STOP poll before writes",
        poll_n - pb, (pre > 0) ? pre : 1);
    if (c[0]) chk(rd_byte == rx, "R6 read byte returned", rd_byte, rx);
    else      chk(rd_byte == old_rd, "R9 write keeps rd_byte", rd_byte, old_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base, pb;
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    chk(!busy && !m_wr && !m_rd && rd_byte == 8'h00, "R1 state in reset", {busy, m_wr, m_rd, rd_byte}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !m_wr && !m_rd, "R1 quiet after reset", {busy, m_wr, m_rd}, 0);
    chk(rd_byte == 8'h00, "R1 rd_byte cleared", rd_byte, 0);

    // Table walk: transactions back to back, some behind a pending STOP.
    for (int k = 0; k < NVEC; k++)
      run_op(VEC[k][31:24], VEC[k][23:16], VEC[k][15:8], int'(VEC[k][7:0]));

    // R8: interrupt while idle does nothing.
    repeat (10) @(negedge clk);
    base = log_n; pb = poll_n; hold = rd_byte;
    irq_force = 1'b1;
    repeat (6) @(negedge clk);
    irq_force = 1'b0;
    repeat (3) @(negedge clk);
    chk(log_n == base && poll_n == pb && !busy, "R8 idle irq ignored", log_n - base + poll_n - pb, 0);
    chk(rd_byte == hold, "R9 rd_byte held while idle", rd_byte, hold);

    // R2: go while busy is ignored.
    base = log_n;
    cmd = 8'h42; wd = 8'h99; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (3) @(negedge clk);
    cmd = 8'h41; wd = 8'h11; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_idle();
    verify(base, 8'h42, 8'h99);
    base = log_n;
    repeat (20) @(negedge clk);
    chk(!busy && log_n == base, "R2 no second transaction", log_n - base, 0);
    chk(rd_byte == hold, "R9 rd_byte held after write", rd_byte, hold);

    // R10: never a read and a write in one cycle.
    chk(both_n == 0, "R10 single access per cycle", both_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule